// File: doc/BRIEF.md
# Flash Command and Address Front End

This block sits on the device side of an 8-bit flash bus. It watches an asynchronous write strobe, brings it into the system clock domain, and on each rising edge of that strobe takes the byte on the bus as a command (command-latch high) or as an address (address-latch high). It decodes the command set, gathers address bytes into column, page and sector fields, and enforces the legal order of each multi-step command. When a sequence is complete it sends a one-cycle operation request to the internal array engine. The engine reports back busy, done and pass/fail.

Two further byte sources are built in: a status byte and a two-byte identification sequence. `out_mode` tells the surrounding output multiplexer which source drives the bus. Status mode is sticky, so a host that polls status during a read must leave it explicitly. Commands that arrive while the engine is busy are filtered so that only a status query and, during reads, a read stop get through.

An undefined command, or a command out of sequence, sets a sticky error flag and starts nothing. Bus fields must stay stable for at least three clock cycles after the write strobe rises.

Top module: `flash_cmd_front`

## Requirements
- R1: A rising edge of `we_n` is taken as a command when `cle`=1 and `ale`=0, and as an address when `ale`=1 and `cle`=0. When both are high the edge sets `cmd_err`. An issued operation is a one-cycle `op_valid` pulse with `op_kind` in 1..6.
- R2: Command 00H followed by four address bytes b1..b4 issues read (`op_kind`=1), and 0FH issues sequential read (`op_kind`=2). The fields are `op_col`={b2[0],b1}, `op_page`=b2[2:1] and `op_sector`={b4[4:0],b3}.
- R3: A nonzero value in b2[7:3] or b4[7:5] sets `cmd_err`. The operation is still issued.
- R4: 80H, four address bytes, any number of data bytes (both latch signals low), then 10H issues program (`op_kind`=3). Ending with 1FH instead issues rewrite (`op_kind`=5). Any other command after 80H sets `cmd_err`, abandons the sequence and issues nothing.
- R5: 60H, two sector bytes (they take the b3/b4 positions), then D0H issues erase (`op_kind`=4) with column and page zero. Any other command in place of D0H sets `cmd_err` and issues nothing.
- R6: With `wp_n`=0, the closing 10H, 1FH or D0H issues no operation and does not set `cmd_err`.
- R7: While `eng_busy`=1, only 70H and F0H have any effect. F0H issues read stop (`op_kind`=6) only when the running operation is a read or sequential read; otherwise it is ignored. Ignored bytes do not set `cmd_err`.
- R8: In status mode (`out_mode`=1), `reg_byte` is {`wp_n`, not busy, 00000, fail}. The fail bit is the `eng_fail` value captured at the last `eng_done`, and it reads 0 while busy.
- R9: 70H selects status mode, and status mode stays until 00H arrives while ready. If a read or sequential read is in progress, that 00H returns to array mode (`out_mode`=0) with no new request and no address.
- R10: 90H followed by one address byte selects ID mode (`out_mode`=2). `reg_byte` shows 07H, then DEV_CODE after the first rising edge of `re_n`, then 00H.
- R11: An undefined command, or a 10H, 1FH or D0H outside its sequence, sets `cmd_err`. The error stays set until reset, and no operation is issued.
- R12: C0H sets `deep_stby`. While it is set, every bus byte except command C1H is ignored, and C1H clears it.
- R13: F0H while ready issues read stop (`op_kind`=6) and returns `out_mode` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_n | input | 1 | Asynchronous write strobe, latches on rising edge |
| re_n | input | 1 | Asynchronous read strobe, steps the ID sequence on rising edge |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte |
| eng_busy | input | 1 | Engine busy |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Engine result, valid with eng_done |
| op_valid | output | 1 | Operation request pulse |
| op_kind | output | 3 | 1 read, 2 seq read, 3 program, 4 erase, 5 rewrite, 6 read stop |
| op_col | output | 9 | Column address |
| op_page | output | 2 | Page address |
| op_sector | output | 13 | Sector address |
| out_mode | output | 2 | 0 array data, 1 status byte, 2 ID byte |
| reg_byte | output | 8 | Status or ID byte |
| deep_stby | output | 1 | Deep standby state |
| cmd_err | output | 1 | Sticky sequence error |

## Verification
The bench targets the busy filter. A design that acted on erase setup while busy would issue a request. One that honoured read stop during a program would abort the wrong operation. It also checks the two-phase sequences by placing a wrong command after 80H and 60H; a lax decoder would go ahead and start the operation. Status stickiness is tested by sending read strobes and a 00H with and without a pending read. A decoder that drops status mode too early, or restarts a read, shows up as a wrong `out_mode` or an extra request. Write protect, reserved address bits, the fail bit being masked while busy, and deep standby ignoring every byte but C1H are each checked at the ports.

// File: rtl/flash_cmd_front.sv
module flash_cmd_front #(
  parameter logic [7:0] MFR_CODE = 8'h07,
  parameter logic [7:0] DEV_CODE = 8'h51,
  parameter int unsigned SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_n,
  input  logic        re_n,
  input  logic        cle,
  input  logic        ale,
  input  logic        wp_n,
  input  logic [7:0]  io_in,
  input  logic        eng_busy,
  input  logic        eng_done,
  input  logic        eng_fail,
  output logic        op_valid,
  output logic [2:0]  op_kind,
  output logic [8:0]  op_col,
  output logic [1:0]  op_page,
  output logic [12:0] op_sector,
  output logic [1:0]  out_mode,
  output logic [7:0]  reg_byte,
  output logic        deep_stby,
  output logic        cmd_err
);
  localparam logic [2:0] K_NONE = 3'd0, K_READ = 3'd1, K_SEQ = 3'd2, K_PROG = 3'd3,
                         K_ERASE = 3'd4, K_REWR = 3'd5, K_STOP = 3'd6;
  localparam logic [1:0] M_ARR = 2'd0, M_STAT = 2'd1, M_ID = 2'd2;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_ERCONF, PH_IDADDR} phase_t;

  logic [SYNC:0] we_sh, re_sh;
  logic we_rise, re_rise, is_cmd, is_adr, is_both;
  phase_t phase;
  logic [1:0]  acnt, id_idx;
  logic [2:0]  pend, ctx, cur_op;
  logic [8:0]  col_q;
  logic [1:0]  page_q;
  logic [12:0] sec_q;
  logic        fail_q;

  assign we_rise = we_sh[SYNC-1] & ~we_sh[SYNC];
  assign re_rise = re_sh[SYNC-1] & ~re_sh[SYNC];
  assign is_cmd  = cle & ~ale;
  assign is_adr  = ale & ~cle;
  assign is_both = cle & ale;

  assign op_col    = col_q;
  assign op_page   = page_q;
  assign op_sector = sec_q;

  assign reg_byte = (out_mode == M_STAT) ? {wp_n, ~eng_busy, 5'b0, fail_q & ~eng_busy} :
                    (out_mode == M_ID)   ? ((id_idx == 2'd0) ? MFR_CODE :
                                            (id_idx == 2'd1) ? DEV_CODE : 8'h00) :
                    8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_sh <= '1;
      re_sh <= '1;
    end else begin
      we_sh <= {we_sh[SYNC-1:0], we_n};
      re_sh <= {re_sh[SYNC-1:0], re_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      acnt      <= '0;
      id_idx    <= '0;
      pend      <= K_NONE;
      ctx       <= K_NONE;
      cur_op    <= K_NONE;
      col_q     <= '0;
      page_q    <= '0;
      sec_q     <= '0;
      fail_q    <= 1'b0;
      op_valid  <= 1'b0;
      op_kind   <= K_NONE;
      out_mode  <= M_ARR;
      deep_stby <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      op_valid <= 1'b0;
      if (eng_done) fail_q <= eng_fail;
      if (re_rise && out_mode == M_ID && id_idx != 2'd2) id_idx <= id_idx + 2'd1;

      if (we_rise) begin
        if (deep_stby) begin
          if (is_cmd && io_in == 8'hC1) deep_stby <= 1'b0;
        end else if (eng_busy) begin
          if (is_cmd && io_in == 8'h70) begin
            out_mode <= M_STAT;
          end else if (is_cmd && io_in == 8'hF0 && (cur_op == K_READ || cur_op == K_SEQ)) begin
            op_valid <= 1'b1;
            op_kind  <= K_STOP;
            cur_op   <= K_STOP;
            ctx      <= K_NONE;
            out_mode <= M_ARR;
            phase    <= PH_IDLE;
          end
        end else if (is_both) begin
          cmd_err <= 1'b1;
          phase   <= PH_IDLE;
        end else if (is_cmd) begin
          case (phase)
            PH_DATA: begin
              phase <= PH_IDLE;
              if (io_in == 8'h10 || io_in == 8'h1F) begin
                if (wp_n) begin
                  op_valid <= 1'b1;
                  op_kind  <= (io_in == 8'h10) ? K_PROG : K_REWR;
                  cur_op   <= (io_in == 8'h10) ? K_PROG : K_REWR;
                  ctx      <= K_NONE;
                end
              end else begin
                cmd_err <= 1'b1;
              end
            end
            PH_ERCONF: begin
              phase <= PH_IDLE;
              if (io_in == 8'hD0) begin
                if (wp_n) begin
                  op_valid <= 1'b1;
                  op_kind  <= K_ERASE;
                  cur_op   <= K_ERASE;
                  ctx      <= K_NONE;
                end
              end else begin
                cmd_err <= 1'b1;
              end
            end
            PH_ADDR, PH_IDADDR: begin
              cmd_err <= 1'b1;
              phase   <= PH_IDLE;
            end
            default: begin
              case (io_in)
                8'h00: begin
                  if (out_mode == M_STAT && ctx != K_NONE) begin
                    out_mode <= M_ARR;
                  end else begin
                    phase <= PH_ADDR;
                    pend  <= K_READ;
                    acnt  <= 2'd0;
                  end
                end
                8'h0F: begin
                  phase <= PH_ADDR;
                  pend  <= K_SEQ;
                  acnt  <= 2'd0;
                end
                8'h80: begin
                  phase <= PH_ADDR;
                  pend  <= K_PROG;
                  acnt  <= 2'd0;
                end
                8'h60: begin
                  phase  <= PH_ADDR;
                  pend   <= K_ERASE;
                  acnt   <= 2'd2;
                  col_q  <= '0;
                  page_q <= '0;
                end
                8'h70: out_mode <= M_STAT;
                8'h90: phase <= PH_IDADDR;
                8'hF0: begin
                  op_valid <= 1'b1;
                  op_kind  <= K_STOP;
                  cur_op   <= K_STOP;
                  ctx      <= K_NONE;
                  out_mode <= M_ARR;
                end
                8'hC0: deep_stby <= 1'b1;
                8'hC1: ;
                default: cmd_err <= 1'b1;
              endcase
            end
          endcase
        end else if (is_adr) begin
          if (phase == PH_ADDR) begin
            case (acnt)
              2'd0: col_q[7:0] <= io_in;
              2'd1: begin
                col_q[8] <= io_in[0];
                page_q   <= io_in[2:1];
                if (io_in[7:3] != 5'b0) cmd_err <= 1'b1;
              end
              2'd2: sec_q[7:0] <= io_in;
              default: begin
                sec_q[12:8] <= io_in[4:0];
                if (io_in[7:5] != 3'b0) cmd_err <= 1'b1;
              end
            endcase
            acnt <= acnt + 2'd1;
            if (acnt == 2'd3) begin
              case (pend)
                K_READ, K_SEQ: begin
                  op_valid <= 1'b1;
                  op_kind  <= pend;
                  cur_op   <= pend;
                  ctx      <= pend;
                  out_mode <= M_ARR;
                  phase    <= PH_IDLE;
                end
                K_PROG:  phase <= PH_DATA;
                default: phase <= PH_ERCONF;
              endcase
            end
          end else if (phase == PH_IDADDR) begin
            out_mode <= M_ID;
            id_idx   <= 2'd0;
            phase    <= PH_IDLE;
          end else begin
            cmd_err <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_front_chk.sv
module flash_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [2:0] op_kind,
  input logic       eng_busy,
  input logic       wp_n,
  input logic [1:0] out_mode,
  input logic       deep_stby,
  input logic       cmd_err
);
  assert_kind_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_kind >= 3'd1 && op_kind <= 3'd6));

  assert_busy_only_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && $past(eng_busy)) |-> op_kind == 3'd6);

  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_kind == 3'd3 || op_kind == 3'd4 || op_kind == 3'd5)) |-> $past(wp_n));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  assert_dstby_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    deep_stby |-> !op_valid);

  assert_dstby_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_stby && $past(deep_stby)) |-> $stable(out_mode));

  assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode != 2'd3);
endmodule

bind flash_cmd_front flash_cmd_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .eng_busy(eng_busy), .wp_n(wp_n), .out_mode(out_mode),
  .deep_stby(deep_stby), .cmd_err(cmd_err)
);

// File: tb/sim_flash_cmd_front.sv
`timescale 1ns/1ps
module sim_flash_cmd_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we_n = 1'b1, re_n = 1'b1, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic eng_busy = 1'b0, eng_done = 1'b0, eng_fail = 1'b0;
  logic op_valid, deep_stby, cmd_err;
  logic [2:0] op_kind;
  logic [8:0] op_col;
  logic [1:0] op_page, out_mode;
  logic [12:0] op_sector;
  logic [7:0] reg_byte;

  int n_chk = 0, n_bad = 0, ops = 0;
  logic [2:0] lk;
  logic [8:0] lc;
  logic [1:0] lp;
  logic [12:0] ls;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_front u0 (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .re_n(re_n), .cle(cle), .ale(ale),
    .wp_n(wp_n), .io_in(io_in), .eng_busy(eng_busy), .eng_done(eng_done),
    .eng_fail(eng_fail), .op_valid(op_valid), .op_kind(op_kind), .op_col(op_col),
    .op_page(op_page), .op_sector(op_sector), .out_mode(out_mode),
    .reg_byte(reg_byte), .deep_stby(deep_stby), .cmd_err(cmd_err)
  );

  always @(posedge clk) if (op_valid) begin
    ops <= ops + 1; lk <= op_kind; lc <= op_col; lp <= op_page; ls <= op_sector;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; we_n = 1; re_n = 1; cle = 0; ale = 0; wp_n = 1; io_in = 0;
    eng_busy = 0; eng_done = 0; eng_fail = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; io_in = d; we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1;
    repeat (5) @(negedge clk);
    cle = 0; ale = 0;
  endtask

  task automatic cmd(input logic [7:0] d); wr(1, 0, d); endtask
  task automatic adr(input logic [7:0] d); wr(0, 1, d); endtask
  task automatic adr4(input logic [7:0] a, b, c, d); adr(a); adr(b); adr(c); adr(d); endtask

  task automatic rd_pulse();
    @(negedge clk); re_n = 0;
    repeat (2) @(negedge clk); re_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset op_valid", op_valid, 0);
    chk("R9 reset out_mode", out_mode, 0);
    chk("R11 reset cmd_err", cmd_err, 0);
    chk("R12 reset deep_stby", deep_stby, 0);
  endtask

  task automatic t_read();
    int o;
    do_reset(); o = ops;
    cmd(8'h00); adr4(8'h34, 8'h05, 8'hAB, 8'h1C);
    chk("R1 one read request", ops - o, 1);
    chk("R2 read kind", lk, 1);
    chk("R2 column", lc, 9'h134);
    chk("R2 page", lp, 2);
    chk("R2 sector", ls, 13'h1CAB);
    chk("R2 no error", cmd_err, 0);
    cmd(8'h0F); adr4(8'hFF, 8'h06, 8'h00, 8'h1F);
    chk("R2 seq kind", lk, 2);
    chk("R2 seq sector", ls, 13'h1F00);
    chk("R2 seq column", lc, 9'h0FF);
  endtask

  task automatic t_reserved();
    int o;
    do_reset(); o = ops;
    cmd(8'h00); adr4(8'h00, 8'h08, 8'h00, 8'h00);
    chk("R3 cycle2 reserved error", cmd_err, 1);
    chk("R3 still issued", ops - o, 1);
    do_reset();
    cmd(8'h00); adr4(8'h00, 8'h00, 8'h00, 8'h20);
    chk("R3 cycle4 reserved error", cmd_err, 1);
  endtask

  task automatic t_prog();
    int o;
    do_reset(); o = ops;
    cmd(8'h80); adr4(8'h10, 8'h02, 8'h22, 8'h03);
    wr(0, 0, 8'hA5); wr(0, 0, 8'h5A); wr(0, 0, 8'h10);
    chk("R4 no op before confirm", ops - o, 0);
    cmd(8'h10);
    chk("R4 program kind", lk, 3);
    chk("R4 program sector", ls, 13'h0322);
    cmd(8'h80); adr4(8'h00, 8'h00, 8'h01, 8'h00); cmd(8'h1F);
    chk("R4 rewrite kind", lk, 5);
    chk("R4 two requests", ops - o, 2);
    chk("R4 no error", cmd_err, 0);
    o = ops;
    cmd(8'h80); adr4(8'h00, 8'h00, 8'h01, 8'h00); cmd(8'h60);
    chk("R4 wrong confirm error", cmd_err, 1);
    chk("R4 wrong confirm no op", ops - o, 0);
    cmd(8'h10);
    chk("R11 orphan confirm no op", ops - o, 0);
  endtask

  task automatic t_erase();
    int o;
    do_reset(); o = ops;
    cmd(8'h60); adr(8'h55); adr(8'h03); cmd(8'hD0);
    chk("R5 erase kind", lk, 4);
    chk("R5 erase sector", ls, 13'h0355);
    chk("R5 erase column zero", lc, 0);
    chk("R5 erase page zero", lp, 0);
    chk("R5 one request", ops - o, 1);
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'h00);
    chk("R5 wrong confirm error", cmd_err, 1);
    chk("R5 wrong confirm no op", ops - o, 1);
  endtask

  task automatic t_wp();
    int o;
    do_reset(); o = ops; wp_n = 0;
    cmd(8'h80); adr4(8'h00, 8'h00, 8'h02, 8'h00); cmd(8'h10);
    cmd(8'h60); adr(8'h02); adr(8'h00); cmd(8'hD0);
    cmd(8'h80); adr4(8'h00, 8'h00, 8'h02, 8'h00); cmd(8'h1F);
    chk("R6 protected no op", ops - o, 0);
    chk("R6 protected no error", cmd_err, 0);
    cmd(8'h70);
    chk("R8 protected status", reg_byte, 8'h40);
  endtask

  task automatic t_busy();
    int o;
    do_reset();
    cmd(8'h00); adr4(0, 0, 8'h05, 0);
    eng_busy = 1; o = ops;
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0); cmd(8'h33);
    chk("R7 busy ignores others", ops - o, 0);
    chk("R7 busy no error", cmd_err, 0);
    cmd(8'h70);
    chk("R7 busy status mode", out_mode, 1);
    chk("R8 busy status byte", reg_byte, 8'h80);
    cmd(8'hF0);
    chk("R7 busy read stop", ops - o, 1);
    chk("R7 stop kind", lk, 6);
    @(negedge clk) eng_busy = 0;
    cmd(8'h80); adr4(0, 0, 8'h07, 0); cmd(8'h10);
    eng_busy = 1; o = ops;
    cmd(8'hF0);
    chk("R7 stop ignored in program", ops - o, 0);
    @(negedge clk) eng_busy = 0;
  endtask

  task automatic t_status();
    do_reset();
    cmd(8'h70);
    chk("R8 ready pass status", reg_byte, 8'hC0);
    @(negedge clk) eng_busy = 1;
    @(negedge clk) begin eng_done = 1; eng_fail = 1; end
    @(negedge clk) begin eng_done = 0; eng_fail = 0; end
    repeat (2) @(negedge clk);
    chk("R8 fail masked while busy", reg_byte, 8'h80);
    eng_busy = 0;
    repeat (2) @(negedge clk);
    chk("R8 ready fail status", reg_byte, 8'hC1);
  endtask

  task automatic t_sticky();
    int o;
    do_reset();
    cmd(8'h0F); adr4(0, 0, 8'h09, 0);
    cmd(8'h70); o = ops;
    rd_pulse(); rd_pulse();
    chk("R9 status stays after reads", out_mode, 1);
    cmd(8'h00);
    chk("R9 00 returns to array", out_mode, 0);
    chk("R9 no new request", ops - o, 0);
    cmd(8'h70); cmd(8'hF0);
    chk("R13 ready stop kind", lk, 6);
    chk("R13 stop clears mode", out_mode, 0);
    cmd(8'h70); cmd(8'h00);
    chk("R9 00 without read starts address", out_mode, 1);
  endtask

  task automatic t_id();
    do_reset();
    cmd(8'h90); adr(8'h00);
    chk("R10 id mode", out_mode, 2);
    chk("R10 first id byte", reg_byte, 8'h07);
    rd_pulse();
    chk("R10 second id byte", reg_byte, 8'h51);
    rd_pulse();
    chk("R10 after id bytes", reg_byte, 8'h00);
  endtask

  task automatic t_undef();
    int o;
    do_reset(); o = ops;
    cmd(8'h33);
    chk("R11 undefined error", cmd_err, 1);
    do_reset();
    cmd(8'hD0);
    chk("R11 lone D0 error", cmd_err, 1);
    chk("R11 no op", ops - o, 0);
    do_reset();
    wr(1, 1, 8'h00);
    chk("R1 both latches error", cmd_err, 1);
  endtask

  task automatic t_dstby();
    int o;
    do_reset(); o = ops;
    cmd(8'hC0);
    chk("R12 deep standby set", deep_stby, 1);
    cmd(8'h00); adr4(0, 0, 1, 0); cmd(8'h70); cmd(8'h33);
    chk("R12 ignored no op", ops - o, 0);
    chk("R12 ignored mode", out_mode, 0);
    chk("R12 ignored no error", cmd_err, 0);
    cmd(8'hC1);
    chk("R12 release", deep_stby, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset(); t_read(); t_reserved(); t_prog(); t_erase(); t_wp();
    t_busy(); t_status(); t_sticky(); t_id(); t_undef(); t_dstby();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule